// File: doc/BRIEF.md
# Video mode geometry validator

This block turns the raw values held in a display controller's mode registers into a checked scanout geometry. It reports the pixel format, bytes per pixel, visible width and height, line stride in bytes, frame size in bytes, and the byte offset where scanout starts. A mode-valid flag is raised only when the enable bit is set, the colour depth is supported, both visible dimensions reach a minimum, and the whole frame fits inside video memory.

The register values, the byte-order flag and the configured video memory size are sampled every clock. The two wide products go through a short fixed pipeline, so every result trails its inputs by a constant number of cycles. Downstream scanout logic uses a one-cycle mode-change pulse to rebuild its surface. The pulse fires whenever a valid geometry differs from the last valid geometry that was seen. It does not fire when the mode merely drops out of validity.

Top module: `mode_geom_check`

## Requirements
- R1: The mode is invalid whenever bit 0 of `ctl_enable` is 0. The other bits of `ctl_enable` have no effect on validity.
- R2: A depth of 16 gives `pix_fmt` = 1 (RGB565) and `byte_pp` = 2. A depth of 32 gives `byte_pp` = 4, with `pix_fmt` = 2 when `be_fb` = 0 and `pix_fmt` = 3 when `be_fb` = 1. Any other depth gives `pix_fmt` = 0, `byte_pp` = 0, and an invalid mode.
- R3: `line_stride` equals the larger of `ctl_vwidth` and `ctl_xres`, multiplied by `byte_pp`.
- R4: `frame_bytes` equals `line_stride` multiplied by `ctl_yres`.
- R5: `start_byte` equals `ctl_xoff` × `byte_pp` plus `ctl_yoff` × `line_stride`, computed without truncation. Values above 2^32 must be represented.
- R6: The mode is invalid if `ctl_xres` or `ctl_yres` is below 64. A value of exactly 64 is accepted.
- R7: The mode is invalid if `start_byte` + `frame_bytes` exceeds the memory limit. A frame that ends exactly at the limit is accepted.
- R8: The memory limit is `vmem_cfg` rounded up to the next power of two. For example, a configured 12 MiB acts as 16 MiB.
- R9: All outputs reflect inputs that were held stable across 4 rising clock edges. `mode_ok` and `mode_new` change on the same edge.
- R10: `mode_new` pulses high for exactly one cycle when a valid geometry differs from the last valid one, or when it is the first valid geometry since reset. The pulse does not fire when the mode becomes invalid. It also does not fire when the mode returns to the same geometry after an invalid interval.
- R11: While reset is asserted, `mode_ok` and `mode_new` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_enable | input | DIM_W | Enable register; bit 0 turns the mode on |
| ctl_depth | input | DIM_W | Bits per pixel |
| ctl_xres | input | DIM_W | Visible width in pixels |
| ctl_yres | input | DIM_W | Visible height in lines |
| ctl_vwidth | input | DIM_W | Virtual line width in pixels |
| ctl_xoff | input | DIM_W | Horizontal start offset in pixels |
| ctl_yoff | input | DIM_W | Vertical start offset in lines |
| be_fb | input | 1 | Big-endian byte order for 32-bit pixels |
| vmem_cfg | input | MEM_W | Configured video memory size in bytes |
| pix_fmt | output | 2 | 0 none, 1 RGB565, 2 xRGB little-endian, 3 xRGB big-endian |
| byte_pp | output | 3 | Bytes per pixel (0, 2 or 4) |
| vis_w | output | DIM_W | Visible width |
| vis_h | output | DIM_W | Visible height |
| line_stride | output | DIM_W+2 | Bytes per line |
| frame_bytes | output | 2*DIM_W+2 | Frame size in bytes |
| start_byte | output | 2*DIM_W+3 | Scanout start offset in bytes |
| mode_ok | output | 1 | Geometry passes every check |
| mode_new | output | 1 | One-cycle pulse on a new valid geometry |

## Verification
Each result is due on the fourth rising edge after an input change: one edge for decode, two for the products, and one for the final sum, check and compare. After reset is released, two more edges pass through the reset synchronizer. For every vector, the bench samples on the falling edge after the third rising edge and confirms that `mode_ok` still shows the previous vector's result and that `mode_new` is low. It then samples after the fourth edge for the full geometry, and after the fifth to confirm that the change pulse has already dropped. The reset test does not assume a fixed latency; it watches a window of falling edges and counts exactly one change pulse.

// File: rtl/mg_pkg.sv
package mg_pkg;
  typedef enum logic [1:0] {
    PIX_NONE    = 2'd0,
    PIX_RGB565  = 2'd1,
    PIX_XRGB_LE = 2'd2,
    PIX_XRGB_BE = 2'd3
  } pix_fmt_e;
endpackage

// File: rtl/mg_decode.sv
module mg_decode
  import mg_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int MEM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] ctl_enable,
  input  logic [DIM_W-1:0] ctl_depth,
  input  logic [DIM_W-1:0] ctl_xres,
  input  logic [DIM_W-1:0] ctl_yres,
  input  logic [DIM_W-1:0] ctl_vwidth,
  input  logic [DIM_W-1:0] ctl_xoff,
  input  logic [DIM_W-1:0] ctl_yoff,
  input  logic             be_fb,
  input  logic [MEM_W-1:0] vmem_cfg,
  output logic             s1_ok,
  output pix_fmt_e         s1_fmt,
  output logic [2:0]       s1_bpp,
  output logic [DIM_W-1:0] s1_w,
  output logic [DIM_W-1:0] s1_h,
  output logic [DIM_W-1:0] s1_veff,
  output logic [DIM_W-1:0] s1_xoff,
  output logic [DIM_W-1:0] s1_yoff,
  output logic [MEM_W:0]   s1_lim
);
  function automatic logic [MEM_W:0] pow2_up(input logic [MEM_W-1:0] v);
    logic [MEM_W:0] r;
    r = {{MEM_W{1'b0}}, 1'b1};
    for (int i = 0; i < MEM_W; i++) begin
      if (r < {1'b0, v}) r = r << 1;
    end
    return r;
  endfunction

  pix_fmt_e         fmt_n;
  logic [2:0]       bpp_n;
  logic             ok_n;
  logic [DIM_W-1:0] veff_n;
  logic [MEM_W:0]   lim_n;

  always_comb begin
    fmt_n = PIX_NONE;
    bpp_n = 3'd0;
    if (ctl_depth == DIM_W'(16)) begin
      fmt_n = PIX_RGB565;
      bpp_n = 3'd2;
    end else if (ctl_depth == DIM_W'(32)) begin
      fmt_n = be_fb ? PIX_XRGB_BE : PIX_XRGB_LE;
      bpp_n = 3'd4;
    end
    ok_n   = ctl_enable[0] && (fmt_n != PIX_NONE);
    veff_n = (ctl_vwidth > ctl_xres) ? ctl_vwidth : ctl_xres;
    lim_n  = pow2_up(vmem_cfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ok   <= 1'b0;
      s1_fmt  <= PIX_NONE;
      s1_bpp  <= 3'd0;
      s1_w    <= '0;
      s1_h    <= '0;
      s1_veff <= '0;
      s1_xoff <= '0;
      s1_yoff <= '0;
      s1_lim  <= {{MEM_W{1'b0}}, 1'b1};
    end else begin
      s1_ok   <= ok_n;
      s1_fmt  <= fmt_n;
      s1_bpp  <= bpp_n;
      s1_w    <= ctl_xres;
      s1_h    <= ctl_yres;
      s1_veff <= veff_n;
      s1_xoff <= ctl_xoff;
      s1_yoff <= ctl_yoff;
      s1_lim  <= lim_n;
    end
  end

  // R2: a supported format always carries 2 or 4 bytes per pixel
  assert_fmt_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_fmt != PIX_NONE) |-> ($countones(s1_bpp) == 1 && s1_bpp != 3'd1));

  // R8: the memory limit is always a single power of two
  assert_lim_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s1_lim) == 1);
endmodule

// File: rtl/mg_mult.sv
module mg_mult
  import mg_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int MEM_W = 32,
  localparam int STR_W = DIM_W + 2,
  localparam int SZ_W  = STR_W + DIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_ok,
  input  pix_fmt_e         s1_fmt,
  input  logic [2:0]       s1_bpp,
  input  logic [DIM_W-1:0] s1_w,
  input  logic [DIM_W-1:0] s1_h,
  input  logic [DIM_W-1:0] s1_veff,
  input  logic [DIM_W-1:0] s1_xoff,
  input  logic [DIM_W-1:0] s1_yoff,
  input  logic [MEM_W:0]   s1_lim,
  output logic             s3_ok,
  output pix_fmt_e         s3_fmt,
  output logic [2:0]       s3_bpp,
  output logic [DIM_W-1:0] s3_w,
  output logic [DIM_W-1:0] s3_h,
  output logic [STR_W-1:0] s3_stride,
  output logic [STR_W-1:0] s3_xb,
  output logic [SZ_W-1:0]  s3_size,
  output logic [SZ_W-1:0]  s3_yb,
  output logic [MEM_W:0]   s3_lim
);
  // stage 2: per-line products
  logic             s2_ok;
  pix_fmt_e         s2_fmt;
  logic [2:0]       s2_bpp;
  logic [DIM_W-1:0] s2_w, s2_h, s2_yoff;
  logic [STR_W-1:0] s2_stride, s2_xb;
  logic [MEM_W:0]   s2_lim;
  logic [STR_W-1:0] stride_n, xb_n;
  logic [SZ_W-1:0]  size_n, yb_n;

  always_comb begin
    stride_n = STR_W'(s1_veff) * STR_W'(s1_bpp);
    xb_n     = STR_W'(s1_xoff) * STR_W'(s1_bpp);
    size_n   = SZ_W'(s2_stride) * SZ_W'(s2_h);
    yb_n     = SZ_W'(s2_yoff) * SZ_W'(s2_stride);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_ok <= 1'b0; s2_fmt <= PIX_NONE; s2_bpp <= 3'd0;
      s2_w <= '0; s2_h <= '0; s2_yoff <= '0;
      s2_stride <= '0; s2_xb <= '0; s2_lim <= '0;
    end else begin
      s2_ok <= s1_ok; s2_fmt <= s1_fmt; s2_bpp <= s1_bpp;
      s2_w <= s1_w; s2_h <= s1_h; s2_yoff <= s1_yoff;
      s2_stride <= stride_n; s2_xb <= xb_n; s2_lim <= s1_lim;
    end
  end

  // stage 3: per-frame products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_ok <= 1'b0; s3_fmt <= PIX_NONE; s3_bpp <= 3'd0;
      s3_w <= '0; s3_h <= '0; s3_stride <= '0; s3_xb <= '0;
      s3_size <= '0; s3_yb <= '0; s3_lim <= '0;
    end else begin
      s3_ok <= s2_ok; s3_fmt <= s2_fmt; s3_bpp <= s2_bpp;
      s3_w <= s2_w; s3_h <= s2_h; s3_stride <= s2_stride; s3_xb <= s2_xb;
      s3_size <= size_n; s3_yb <= yb_n; s3_lim <= s2_lim;
    end
  end

  // R3: stride never falls short of the visible line in bytes
  assert_stride_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s3_stride >= STR_W'(s3_w) * STR_W'(s3_bpp));
endmodule

// File: rtl/mg_judge.sv
module mg_judge
  import mg_pkg::*;
#(
  parameter int DIM_W   = 16,
  parameter int MEM_W   = 32,
  parameter int MIN_DIM = 64,
  localparam int STR_W = DIM_W + 2,
  localparam int SZ_W  = STR_W + DIM_W,
  localparam int OFF_W = SZ_W + 1,
  localparam int END_W = SZ_W + 2,
  localparam int GEO_W = 2 + 3 + 2 * DIM_W + STR_W + SZ_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s3_ok,
  input  pix_fmt_e         s3_fmt,
  input  logic [2:0]       s3_bpp,
  input  logic [DIM_W-1:0] s3_w,
  input  logic [DIM_W-1:0] s3_h,
  input  logic [STR_W-1:0] s3_stride,
  input  logic [STR_W-1:0] s3_xb,
  input  logic [SZ_W-1:0]  s3_size,
  input  logic [SZ_W-1:0]  s3_yb,
  input  logic [MEM_W:0]   s3_lim,
  output pix_fmt_e         pix_fmt,
  output logic [2:0]       byte_pp,
  output logic [DIM_W-1:0] vis_w,
  output logic [DIM_W-1:0] vis_h,
  output logic [STR_W-1:0] line_stride,
  output logic [SZ_W-1:0]  frame_bytes,
  output logic [OFF_W-1:0] start_byte,
  output logic             mode_ok,
  output logic             mode_new
);
  logic [OFF_W-1:0] off_n;
  logic [END_W-1:0] end_n;
  logic             ok_n, new_n;
  logic [GEO_W-1:0] geo_n, last_geo;
  logic             seen;
  logic [MEM_W:0]   lim_q;

  always_comb begin
    off_n = OFF_W'(s3_xb) + OFF_W'(s3_yb);
    end_n = END_W'(off_n) + END_W'(s3_size);
    ok_n  = s3_ok && (s3_w >= DIM_W'(MIN_DIM)) && (s3_h >= DIM_W'(MIN_DIM))
            && (end_n <= END_W'(s3_lim));
    geo_n = {s3_fmt, s3_bpp, s3_w, s3_h, s3_stride, s3_size, off_n};
    new_n = ok_n && (!seen || (geo_n != last_geo));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_fmt <= PIX_NONE; byte_pp <= 3'd0; vis_w <= '0; vis_h <= '0;
      line_stride <= '0; frame_bytes <= '0; start_byte <= '0;
      mode_ok <= 1'b0; mode_new <= 1'b0; lim_q <= '0;
    end else begin
      pix_fmt <= s3_fmt; byte_pp <= s3_bpp; vis_w <= s3_w; vis_h <= s3_h;
      line_stride <= s3_stride; frame_bytes <= s3_size; start_byte <= off_n;
      mode_ok <= ok_n; mode_new <= new_n; lim_q <= s3_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      last_geo <= '0;
    end else if (ok_n) begin
      seen     <= 1'b1;
      last_geo <= geo_n;
    end
  end

  // R10: the change pulse only accompanies a valid mode
  assert_new_needs_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_new |-> mode_ok);

  // R10: back-to-back pulses need a differing geometry
  assert_new_differs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_new && $past(mode_new)) |->
      ({line_stride, frame_bytes, start_byte, vis_w, vis_h, byte_pp} !=
       $past({line_stride, frame_bytes, start_byte, vis_w, vis_h, byte_pp})
       || pix_fmt != $past(pix_fmt)));

  // R6: a valid mode meets the minimum visible size
  assert_min_dim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok |-> (vis_w >= DIM_W'(MIN_DIM) && vis_h >= DIM_W'(MIN_DIM)));

  // R7: a valid frame ends inside the memory limit
  assert_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok |-> (END_W'(start_byte) + END_W'(frame_bytes) <= END_W'(lim_q)));

  // R2: a valid mode has a supported format
  assert_valid_fmt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok |-> (pix_fmt != PIX_NONE));
endmodule

// File: rtl/mode_geom_check.sv
module mode_geom_check
  import mg_pkg::*;
#(
  parameter int DIM_W   = 16,
  parameter int MEM_W   = 32,
  parameter int MIN_DIM = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIM_W-1:0]     ctl_enable,
  input  logic [DIM_W-1:0]     ctl_depth,
  input  logic [DIM_W-1:0]     ctl_xres,
  input  logic [DIM_W-1:0]     ctl_yres,
  input  logic [DIM_W-1:0]     ctl_vwidth,
  input  logic [DIM_W-1:0]     ctl_xoff,
  input  logic [DIM_W-1:0]     ctl_yoff,
  input  logic                 be_fb,
  input  logic [MEM_W-1:0]     vmem_cfg,
  output logic [1:0]           pix_fmt,
  output logic [2:0]           byte_pp,
  output logic [DIM_W-1:0]     vis_w,
  output logic [DIM_W-1:0]     vis_h,
  output logic [DIM_W+1:0]     line_stride,
  output logic [2*DIM_W+1:0]   frame_bytes,
  output logic [2*DIM_W+2:0]   start_byte,
  output logic                 mode_ok,
  output logic                 mode_new
);
  localparam int STR_W = DIM_W + 2;
  localparam int SZ_W  = STR_W + DIM_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic             s1_ok;
  pix_fmt_e         s1_fmt;
  logic [2:0]       s1_bpp;
  logic [DIM_W-1:0] s1_w, s1_h, s1_veff, s1_xoff, s1_yoff;
  logic [MEM_W:0]   s1_lim;

  logic             s3_ok;
  pix_fmt_e         s3_fmt;
  logic [2:0]       s3_bpp;
  logic [DIM_W-1:0] s3_w, s3_h;
  logic [STR_W-1:0] s3_stride, s3_xb;
  logic [SZ_W-1:0]  s3_size, s3_yb;
  logic [MEM_W:0]   s3_lim;
  pix_fmt_e         fmt_o;

  mg_decode #(.DIM_W(DIM_W), .MEM_W(MEM_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n),
    .ctl_enable(ctl_enable), .ctl_depth(ctl_depth), .ctl_xres(ctl_xres),
    .ctl_yres(ctl_yres), .ctl_vwidth(ctl_vwidth), .ctl_xoff(ctl_xoff),
    .ctl_yoff(ctl_yoff), .be_fb(be_fb), .vmem_cfg(vmem_cfg),
    .s1_ok(s1_ok), .s1_fmt(s1_fmt), .s1_bpp(s1_bpp), .s1_w(s1_w),
    .s1_h(s1_h), .s1_veff(s1_veff), .s1_xoff(s1_xoff), .s1_yoff(s1_yoff),
    .s1_lim(s1_lim)
  );

  mg_mult #(.DIM_W(DIM_W), .MEM_W(MEM_W)) u_mul (
    .clk(clk), .rst_n(rst_int_n),
    .s1_ok(s1_ok), .s1_fmt(s1_fmt), .s1_bpp(s1_bpp), .s1_w(s1_w),
    .s1_h(s1_h), .s1_veff(s1_veff), .s1_xoff(s1_xoff), .s1_yoff(s1_yoff),
    .s1_lim(s1_lim),
    .s3_ok(s3_ok), .s3_fmt(s3_fmt), .s3_bpp(s3_bpp), .s3_w(s3_w),
    .s3_h(s3_h), .s3_stride(s3_stride), .s3_xb(s3_xb), .s3_size(s3_size),
    .s3_yb(s3_yb), .s3_lim(s3_lim)
  );

  mg_judge #(.DIM_W(DIM_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM)) u_jdg (
    .clk(clk), .rst_n(rst_int_n),
    .s3_ok(s3_ok), .s3_fmt(s3_fmt), .s3_bpp(s3_bpp), .s3_w(s3_w),
    .s3_h(s3_h), .s3_stride(s3_stride), .s3_xb(s3_xb), .s3_size(s3_size),
    .s3_yb(s3_yb), .s3_lim(s3_lim),
    .pix_fmt(fmt_o), .byte_pp(byte_pp), .vis_w(vis_w), .vis_h(vis_h),
    .line_stride(line_stride), .frame_bytes(frame_bytes),
    .start_byte(start_byte), .mode_ok(mode_ok), .mode_new(mode_new)
  );

  assign pix_fmt = fmt_o;

  // R11: reset clears the status outputs
  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_int_n |-> (!mode_ok && !mode_new));
endmodule

// File: tb/sim_mode_geom_check.sv
module sim_mode_geom_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] en_r = '0, dep_r = '0, xr_r = '0, yr_r = '0;
  logic [15:0] vw_r = '0, xo_r = '0, yo_r = '0;
  logic        be_r = 1'b0;
  logic [31:0] mem_r = 32'd16777216;
  logic [1:0]  pix_fmt;
  logic [2:0]  byte_pp;
  logic [15:0] vis_w, vis_h;
  logic [17:0] line_stride;
  logic [33:0] frame_bytes;
  logic [34:0] start_byte;
  logic        mode_ok, mode_new;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mode_geom_check u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_enable(en_r), .ctl_depth(dep_r), .ctl_xres(xr_r), .ctl_yres(yr_r),
    .ctl_vwidth(vw_r), .ctl_xoff(xo_r), .ctl_yoff(yo_r), .be_fb(be_r),
    .vmem_cfg(mem_r),
    .pix_fmt(pix_fmt), .byte_pp(byte_pp), .vis_w(vis_w), .vis_h(vis_h),
    .line_stride(line_stride), .frame_bytes(frame_bytes),
    .start_byte(start_byte), .mode_ok(mode_ok), .mode_new(mode_new)
  );

  typedef struct packed {
    logic [15:0] en, dep, xr, yr, vw, xo, yo;
    logic        be;
    logic [31:0] mem;
    logic        ev, ec;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{16'd1,  16'd32, 16'd1024, 16'd768, 16'd0, 16'd0, 16'd0, 1'b0, 32'd16777216, 1'b1, 1'b1, "R2  "},
    '{16'd1,  16'd32, 16'd1024, 16'd768, 16'd0, 16'd0, 16'd0, 1'b1, 32'd16777216, 1'b1, 1'b1, "R2  "},
    '{16'd1,  16'd16, 16'd800,  16'd600, 16'd1024, 16'd8, 16'd2, 1'b0, 32'd16777216, 1'b1, 1'b1, "R5  "},
    '{16'd0,  16'd16, 16'd800,  16'd600, 16'd1024, 16'd8, 16'd2, 1'b0, 32'd16777216, 1'b0, 1'b0, "R1  "},
    '{16'd1,  16'd16, 16'd800,  16'd600, 16'd1024, 16'd8, 16'd2, 1'b0, 32'd16777216, 1'b1, 1'b0, "R10 "},
    '{16'h40, 16'd16, 16'd800,  16'd600, 16'd1024, 16'd8, 16'd2, 1'b0, 32'd16777216, 1'b0, 1'b0, "R1  "},
    '{16'd1,  16'd24, 16'd800,  16'd600, 16'd1024, 16'd8, 16'd2, 1'b0, 32'd16777216, 1'b0, 1'b0, "R2  "},
    '{16'd1,  16'd32, 16'd64,   16'd64,  16'd0, 16'd0, 16'd0, 1'b0, 32'd16777216, 1'b1, 1'b1, "R6  "},
    '{16'd1,  16'd32, 16'd63,   16'd64,  16'd0, 16'd0, 16'd0, 1'b0, 32'd16777216, 1'b0, 1'b0, "R6  "},
    '{16'd1,  16'd32, 16'd64,   16'd63,  16'd0, 16'd0, 16'd0, 1'b0, 32'd16777216, 1'b0, 1'b0, "R6  "},
    '{16'd1,  16'd32, 16'd1024, 16'd4096, 16'd0, 16'd0, 16'd0, 1'b0, 32'd16777216, 1'b1, 1'b1, "R7  "},
    '{16'd1,  16'd32, 16'd1024, 16'd4096, 16'd0, 16'd0, 16'd1, 1'b0, 32'd16777216, 1'b0, 1'b0, "R7  "},
    '{16'd1,  16'd32, 16'd1024, 16'd768, 16'd0, 16'd0, 16'd2500, 1'b0, 32'd12582912, 1'b1, 1'b1, "R8  "},
    '{16'd1,  16'd32, 16'd64,   16'd64,  16'd65535, 16'd65535, 16'd65535, 1'b0, 32'd268435456, 1'b0, 1'b0, "R5  "},
    '{16'd1,  16'd16, 16'd1000, 16'd100, 16'd2000, 16'd0, 16'd0, 1'b0, 32'd16777216, 1'b1, 1'b1, "R3  "}
  };

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    en_r = v.en; dep_r = v.dep; xr_r = v.xr; yr_r = v.yr;
    vw_r = v.vw; xo_r = v.xo; yo_r = v.yo; be_r = v.be; mem_r = v.mem;
  endtask

  task automatic check_geom(input vec_t v, input string req);
    longint bpc, fmt, veff, str, sz, off;
    bpc  = (v.dep == 16) ? 2 : (v.dep == 32) ? 4 : 0;
    fmt  = (v.dep == 16) ? 1 : (v.dep == 32) ? (v.be ? 3 : 2) : 0;
    veff = (v.vw > v.xr) ? longint'(v.vw) : longint'(v.xr);
    str  = veff * bpc;
    sz   = str * longint'(v.yr);
    off  = longint'(v.xo) * bpc + longint'(v.yo) * str;
    chk("R2", {req, " pix_fmt"}, longint'(pix_fmt), fmt);
    chk("R2", {req, " byte_pp"}, longint'(byte_pp), bpc);
    chk("R9", {req, " vis_w"}, longint'(vis_w), longint'(v.xr));
    chk("R9", {req, " vis_h"}, longint'(vis_h), longint'(v.yr));
    chk("R3", {req, " line_stride"}, longint'(line_stride), str);
    chk("R4", {req, " frame_bytes"}, longint'(frame_bytes), sz);
    chk("R5", {req, " start_byte"}, longint'(start_byte), off);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit prev_ok;
    int pulses;
    repeat (3) @(negedge clk);
    chk("R11", "mode_ok in reset", longint'(mode_ok), 0);
    chk("R11", "mode_new in reset", longint'(mode_new), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", "mode_ok with enable clear", longint'(mode_ok), 0);
    prev_ok = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string req;
      req = $sformatf("%s vec%0d", VEC[i].tag, i);
      drive(VEC[i]);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", {req, " mode_ok held after 3 edges"}, longint'(mode_ok), longint'(prev_ok));
      chk("R9", {req, " mode_new low after 3 edges"}, longint'(mode_new), 0);
      @(negedge clk);
      chk("R7", {req, " mode_ok"}, longint'(mode_ok), longint'(VEC[i].ev));
      chk("R10", {req, " mode_new"}, longint'(mode_new), longint'(VEC[i].ec));
      check_geom(VEC[i], req);
      @(negedge clk);
      chk("R10", {req, " mode_new one cycle"}, longint'(mode_new), 0);
      prev_ok = VEC[i].ev;
    end

    // R11 / R10: reset mid-run, then the first valid geometry pulses once
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "mode_ok during reset", longint'(mode_ok), 0);
    chk("R11", "mode_new during reset", longint'(mode_new), 0);
    rst_n = 1'b1;
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (mode_new) pulses++;
    end
    chk("R10", "pulses after reset release", longint'(pulses), 1);
    chk("R10", "mode_ok after reset release", longint'(mode_ok), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule